// File: doc/BRIEF.md
# Processor Standby Wake Controller

This block sits next to a processor core and decides whether the core's clocks run. It has two operating modes. In Run the core clock enable is high and the core works normally. In Standby the core clock enable is low while power stays applied; only a small always-on wake domain keeps running, so that the block can notice a reason to resume.

The core asks to sleep by pulsing either a wait-for-interrupt request or a wait-for-event request. The block records which kind of request put it to sleep. Several conditions can end Standby:

- any raw interrupt line, whether masked or not;
- a debug request, whatever the debug-enable flag says;
- an event pulse, but only when the sleep began with a wait-for-event request.

When the block wakes, it registers the wake condition, reports a cause code, and raises the core clock enable one cycle later, so that the gating cell sees a clean edge. Clock gating cells, power switches and interrupt prioritisation belong to other blocks.

Top module: `standbyWakeCtrl`

## Requirements
- R1: In Run, coreClkEn is 1, standbyMode is 0 and wakeLogicEn is 0; this is the state after reset.
- R2: A wfiReq or wfeReq sampled in Run with no wake condition pending moves the block to Standby: after that edge coreClkEn is 0, standbyMode is 1 and wakeLogicEn is 1.
- R3: In Standby, any set bit of irqRaw wakes the block, whatever the value of irqMask.
- R4: In Standby, eventPulse wakes the block only if the entry was a wait-for-event request. When wfiReq and wfeReq arrive together, the entry counts as wait-for-event. After a wait-for-interrupt entry, events leave the block in Standby.
- R5: In Standby, dbgReq wakes the block whether dbgEnable is 0 or 1.
- R6: An active-low rstN asynchronously forces Run mode (coreClkEn=1, standbyMode=0) and sets wakeCause to 0.
- R7: The entry type is stored when Standby begins and is cleared on wake, so an event after a later wait-for-interrupt entry is still ignored.
- R8: A wake condition sampled at clock edge t updates wakeCause at edge t, while coreClkEn and standbyMode keep their Standby values. At edge t+1, coreClkEn returns to 1.
- R9: The wakeCause codes are 0 for reset, 1 for interrupt, 2 for event and 3 for debug. When several causes arrive in the same cycle, debug wins over interrupt, and interrupt wins over event.
- R10: An entry request that arrives in Run while any irqRaw bit or dbgReq is set is ignored, and the block stays in Run. The same holds for a wfeReq that coincides with eventPulse.
- R11: standbyMode is always the inverse of coreClkEn, and both change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on wake domain |
| rstN | input | 1 | Asynchronous reset, active low |
| irqRaw | input | IRQ_W | Raw interrupt lines, level |
| irqMask | input | IRQ_W | Interrupt mask (1 = masked); it does not affect wake |
| eventPulse | input | 1 | Single-cycle event pulse |
| dbgReq | input | 1 | Debug request |
| dbgEnable | input | 1 | Debug enable flag; it does not affect wake |
| wfiReq | input | 1 | Wait-for-interrupt request pulse from the core |
| wfeReq | input | 1 | Wait-for-event request pulse from the core |
| coreClkEn | output | 1 | Enable for the core and memory array clocks |
| wakeLogicEn | output | 1 | Enable for the small wake-detection domain |
| standbyMode | output | 1 | 1 in Standby, 0 in Run |
| wakeCause | output | 2 | Cause of the most recent wake or reset |

## Verification
The properties assume that every input is synchronous to clk and settles before the sampling edge. They also assume that eventPulse, wfiReq and wfeReq each last exactly one cycle. The bench drives all inputs on the falling edge and lowers each pulse after a single cycle. It holds an interrupt or debug request only until the block leaves Standby, so a property's trigger cycle is always well defined. The reset scenario pulls rstN low in the middle of a cycle and releases it on a falling edge, which keeps reset release away from the sampling edge.

// File: rtl/swcPkg.sv
package swcPkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STANDBY = 2'd1,
    ST_WAKE    = 2'd2
  } modeState_t;

  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_RESET = 2'd0,
    CAUSE_IRQ   = 2'd1,
    CAUSE_EVENT = 2'd2,
    CAUSE_DEBUG = 2'd3
  } wakeCause_t;

  typedef struct packed {
    logic enter;
    logic wake;
    logic resume;
  } ctrlStrobe_t;
endpackage

// File: rtl/swcControl.sv
module swcControl
  import swcPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wfiReq,
  input  logic        wfeReq,
  input  logic        wakeNow,
  input  logic        entryBlocked,
  output ctrlStrobe_t strobe,
  output modeState_t  state
);
  modeState_t stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if ((wfiReq || wfeReq) && !entryBlocked) begin
          strobe.enter = 1'b1;
          stateNext    = ST_STANDBY;
        end
      end
      ST_STANDBY: begin
        if (wakeNow) begin
          strobe.wake = 1'b1;
          stateNext   = ST_WAKE;
        end
      end
      ST_WAKE: begin
        strobe.resume = 1'b1;
        stateNext     = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/swcDatapath.sv
module swcDatapath
  import swcPkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [IRQ_W-1:0] irqRaw,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic             eventPulse,
  input  logic             dbgReq,
  input  logic             dbgEnable,
  input  logic             wfeReq,
  output logic             wakeNow,
  output logic             entryBlocked,
  output logic             entryWfe,
  output logic             coreClkEn,
  output logic             wakeLogicEn,
  output logic             standbyMode,
  output wakeCause_t       wakeCause
);
  // Masked and unmasked lines are both wake sources; the split keeps the mask visible.
  logic irqMaskedHit, irqOpenHit, irqAny;
  logic dbgArmedHit, dbgQuietHit, dbgAny;
  logic eventHit;
  wakeCause_t causeNext;

  assign irqMaskedHit = |(irqRaw & irqMask);
  assign irqOpenHit   = |(irqRaw & ~irqMask);
  assign irqAny       = irqMaskedHit | irqOpenHit;
  assign dbgArmedHit  = dbgReq & dbgEnable;
  assign dbgQuietHit  = dbgReq & ~dbgEnable;
  assign dbgAny       = dbgArmedHit | dbgQuietHit;
  assign eventHit     = entryWfe & eventPulse;

  assign wakeNow      = irqAny | dbgAny | eventHit;
  assign entryBlocked = irqAny | dbgAny | (wfeReq & eventPulse);

  always_comb begin
    if (dbgAny)      causeNext = CAUSE_DEBUG;
    else if (irqAny) causeNext = CAUSE_IRQ;
    else             causeNext = CAUSE_EVENT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryWfe    <= 1'b0;
      coreClkEn   <= 1'b1;
      standbyMode <= 1'b0;
      wakeLogicEn <= 1'b0;
      wakeCause   <= CAUSE_RESET;
    end else begin
      if (strobe.enter) begin
        entryWfe    <= wfeReq;
        coreClkEn   <= 1'b0;
        standbyMode <= 1'b1;
        wakeLogicEn <= 1'b1;
      end
      if (strobe.wake) begin
        wakeCause <= causeNext;
      end
      if (strobe.resume) begin
        entryWfe    <= 1'b0;
        coreClkEn   <= 1'b1;
        standbyMode <= 1'b0;
        wakeLogicEn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/standbyWakeCtrl.sv
module standbyWakeCtrl
  import swcPkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_W-1:0] irqRaw,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic             eventPulse,
  input  logic             dbgReq,
  input  logic             dbgEnable,
  input  logic             wfiReq,
  input  logic             wfeReq,
  output logic             coreClkEn,
  output logic             wakeLogicEn,
  output logic             standbyMode,
  output logic [1:0]       wakeCause
);
  ctrlStrobe_t strobe;
  modeState_t  ctrlState;
  wakeCause_t  causeReg;
  logic        wakeNow, entryBlocked, entryWfe;

  swcControl u_control (
    .clk          (clk),
    .rstN         (rstN),
    .wfiReq       (wfiReq),
    .wfeReq       (wfeReq),
    .wakeNow      (wakeNow),
    .entryBlocked (entryBlocked),
    .strobe       (strobe),
    .state        (ctrlState)
  );

  swcDatapath #(.IRQ_W(IRQ_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .irqRaw       (irqRaw),
    .irqMask      (irqMask),
    .eventPulse   (eventPulse),
    .dbgReq       (dbgReq),
    .dbgEnable    (dbgEnable),
    .wfeReq       (wfeReq),
    .wakeNow      (wakeNow),
    .entryBlocked (entryBlocked),
    .entryWfe     (entryWfe),
    .coreClkEn    (coreClkEn),
    .wakeLogicEn  (wakeLogicEn),
    .standbyMode  (standbyMode),
    .wakeCause    (causeReg)
  );

  assign wakeCause = causeReg;
endmodule

// File: rtl/standbyWakeCtrlChecker.sv
module standbyWakeCtrlChecker
  import swcPkg::*;
#(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input modeState_t       state,
  input logic             entryWfe,
  input logic [IRQ_W-1:0] irqRaw,
  input logic             eventPulse,
  input logic             dbgReq,
  input logic             wfiReq,
  input logic             wfeReq,
  input logic             coreClkEn,
  input logic             standbyMode,
  input logic [1:0]       wakeCause
);
  p_run_clocks_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (coreClkEn && !standbyMode));

  p_irq_wakes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && (|irqRaw)) |=> (state == ST_WAKE));

  p_wfi_ignores_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && !entryWfe && eventPulse && !(|irqRaw) && !dbgReq)
      |=> (state == ST_STANDBY));

  p_debug_wakes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && dbgReq) |=> (state == ST_WAKE && wakeCause == 2'd3));

  p_irq_over_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && !dbgReq && (|irqRaw)) |=> (wakeCause == 2'd1));

  p_clean_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> ($past(state) == ST_WAKE));

  p_entry_blocked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && (wfiReq || wfeReq) && ((|irqRaw) || dbgReq))
      |=> (state == ST_RUN && coreClkEn));

  p_mode_tracks_r11: assert property (@(posedge clk) disable iff (!rstN)
    standbyMode != coreClkEn);
endmodule

bind standbyWakeCtrl standbyWakeCtrlChecker #(.IRQ_W(IRQ_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .state       (ctrlState),
  .entryWfe    (entryWfe),
  .irqRaw      (irqRaw),
  .eventPulse  (eventPulse),
  .dbgReq      (dbgReq),
  .wfiReq      (wfiReq),
  .wfeReq      (wfeReq),
  .coreClkEn   (coreClkEn),
  .standbyMode (standbyMode),
  .wakeCause   (wakeCause)
);

// File: tb/standbyWakeCtrl_test.sv
`timescale 1ns/1ps
module standbyWakeCtrl_test;
  localparam int IRQ_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IRQ_W-1:0] irqRaw = '0;
  logic [IRQ_W-1:0] irqMask = '0;
  logic eventPulse = 1'b0, dbgReq = 1'b0, dbgEnable = 1'b0;
  logic wfiReq = 1'b0, wfeReq = 1'b0;
  logic coreClkEn, wakeLogicEn, standbyMode;
  logic [1:0] wakeCause;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  standbyWakeCtrl #(.IRQ_W(IRQ_W)) uut (
    .clk(clk), .rstN(rstN), .irqRaw(irqRaw), .irqMask(irqMask),
    .eventPulse(eventPulse), .dbgReq(dbgReq), .dbgEnable(dbgEnable),
    .wfiReq(wfiReq), .wfeReq(wfeReq), .coreClkEn(coreClkEn),
    .wakeLogicEn(wakeLogicEn), .standbyMode(standbyMode), .wakeCause(wakeCause)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expectRun(string req);
    check(req, {29'd0, coreClkEn, standbyMode, wakeLogicEn}, 32'b100);
  endtask

  task automatic expectStandby(string req);
    check(req, {29'd0, coreClkEn, standbyMode, wakeLogicEn}, 32'b011);
  endtask

  task automatic enterStandby(bit useWfe, bit useWfi);
    wfeReq = useWfe; wfiReq = useWfi;
    tick();
    wfeReq = 1'b0; wfiReq = 1'b0;
    expectStandby("R2 entry");
  endtask

  task automatic testReset();
    expectRun("R1 reset run");
    check("R6 reset cause", wakeCause, 0);
  endtask

  task automatic testMaskedIrqWake();
    enterStandby(1'b0, 1'b1);
    irqMask = '1; irqRaw = 8'h04;
    tick();
    expectStandby("R8 wake cycle keeps clock off");
    check("R3 masked irq cause", wakeCause, 1);
    irqRaw = '0;
    tick();
    expectRun("R8 clock back one cycle later");
    check("R11 mode low", standbyMode, 0);
  endtask

  task automatic testWfiEventThenDebug();
    irqMask = '0;
    enterStandby(1'b0, 1'b1);
    eventPulse = 1'b1;
    tick();
    eventPulse = 1'b0;
    tick();
    expectStandby("R4 event ignored after wfi");
    dbgEnable = 1'b0; dbgReq = 1'b1;
    tick();
    dbgReq = 1'b0;
    check("R5 debug wake with enable low", wakeCause, 3);
    tick();
    expectRun("R5 back in run");
  endtask

  task automatic testWfeEvent();
    enterStandby(1'b1, 1'b1);
    eventPulse = 1'b1;
    tick();
    eventPulse = 1'b0;
    check("R4 event wake after wfe", wakeCause, 2);
    tick();
    expectRun("R4 run after event wake");
  endtask

  task automatic testPriority();
    enterStandby(1'b1, 1'b0);
    dbgEnable = 1'b1; dbgReq = 1'b1; irqRaw = 8'h80; eventPulse = 1'b1;
    tick();
    dbgReq = 1'b0; irqRaw = '0; eventPulse = 1'b0;
    check("R9 debug over all", wakeCause, 3);
    tick();
    enterStandby(1'b1, 1'b0);
    irqRaw = 8'h01; eventPulse = 1'b1;
    tick();
    irqRaw = '0; eventPulse = 1'b0;
    check("R9 irq over event", wakeCause, 1);
    tick();
    expectRun("R9 run");
  endtask

  task automatic testEntryBlocked();
    irqRaw = 8'h10; wfiReq = 1'b1;
    tick();
    wfiReq = 1'b0; irqRaw = '0;
    expectRun("R10 entry ignored with irq pending");
    dbgReq = 1'b1; wfeReq = 1'b1;
    tick();
    dbgReq = 1'b0; wfeReq = 1'b0;
    expectRun("R10 entry ignored with debug pending");
    eventPulse = 1'b1; wfeReq = 1'b1;
    tick();
    eventPulse = 1'b0; wfeReq = 1'b0;
    expectRun("R10 wfe ignored with event");
  endtask

  task automatic testEntryTypeCleared();
    enterStandby(1'b1, 1'b0);
    irqRaw = 8'h02;
    tick();
    irqRaw = '0;
    tick();
    enterStandby(1'b0, 1'b1);
    eventPulse = 1'b1;
    tick();
    eventPulse = 1'b0;
    tick();
    expectStandby("R7 entry type cleared on wake");
    irqRaw = 8'h01;
    tick();
    irqRaw = '0;
    tick();
  endtask

  task automatic testAsyncReset();
    enterStandby(1'b0, 1'b1);
    #1 rstN = 1'b0;
    #0.5;
    expectRun("R6 async reset forces run");
    check("R6 cause after reset", wakeCause, 0);
    tick();
    rstN = 1'b1;
    tick();
    expectRun("R1 run after reset release");
  endtask

  initial begin
    tick();
    tick();
    rstN = 1'b1;
    tick();
    testReset();
    testMaskedIrqWake();
    testWfiEventThenDebug();
    testWfeEvent();
    testPriority();
    testEntryBlocked();
    testEntryTypeCleared();
    testAsyncReset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule